// File: doc/BRIEF.md
# Bit-Serial NOR-Only Subtractor

This block computes the difference of two W-bit operands one bit position per step, and it builds every logic function from two-input NOR gates. The caller supplies the minuend and the subtrahend already in two's-complement negated form. The subtraction then becomes a plain addition: the minuend, the negated subtrahend and a running carry are combined bit by bit, from the least significant position to the most significant one.

Inside, a small scratch row store stands in for the rows of a compute memory. A single NOR gate reads two rows and writes one row per clock. A fixed nine-entry micro-program runs for each bit position. It takes four NORs to form the XNOR of the operand bits, two NORs to form the next carry into a scratch row, and three NORs to form the difference bit. The difference bit uses the carry that entered the position. The new carry is committed only on the edge that writes the difference bit. A generate parameter picks how operand bits are reached: shift registers, or a bit-indexed select.

Top module: `nor_serial_sub`

## Requirements
- R1: After reset, `diff_out` is all zeros and `done_out` is low.
- R2: On completion, `diff_out` equals `c_in - a` modulo 2^W, where `na_in = (-a) mod 2^W` was presented with the accepted start.
- R3: `done_out` is high for exactly one cycle. It rises on the 9*W-th rising edge after the edge that accepts `start`.
- R4: Each bit position runs nine NOR micro-operations in a fixed order. Four form the XNOR of the operand bits, two form the carry-out, and three form the difference bit, which equals minuend bit XOR negated-subtrahend bit XOR incoming carry.
- R5: The carry into bit 0 is zero, so `na_in = 0` returns the minuend unchanged and zero minus zero gives zero.
- R6: The carry propagates through every position. With minuend 1 and `na_in` all ones, the result is all zeros.
- R7: The carry out of the most significant position is dropped. With minuend all ones and `na_in` all ones, the result is all ones minus one.
- R8: A `start` that arrives while an operation is in progress is ignored. Neither the running result nor its completion cycle changes.
- R9: Operands are captured on the accepting edge. Later changes on `c_in` and `na_in` do not affect the result.
- R10: `diff_out` keeps the previous result until the edge that raises `done_out`.
- R11: Both operand access variants (`ACCESS` 0 = shift registers, 1 = indexed select) give identical results and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the operands (ignored while busy) |
| c_in | input | W | Minuend |
| na_in | input | W | Two's-complement negation of the subtrahend |
| diff_out | output | W | Difference, held until the next completion |
| done_out | output | 1 | One-cycle completion strobe |

## Verification
The bench builds two instances. The first uses W=16 with shift-register access, where full-width carry ripples, the dropped carry-out, a start arriving mid-run and operands changing mid-run are all exercised. The second uses W=4 with indexed access, small enough to run every minuend and subtrahend pair in full and to confirm that the two access variants agree at every value, including the 9*W latency.

// File: rtl/nsub_pkg.sv
package nsub_pkg;

   // Row numbering of the emulated compute store. Rows 0..2 are live views.
   typedef enum logic [3:0] {
      ROW_C  = 4'd0,
      ROW_NA = 4'd1,
      ROW_B  = 4'd2,
      ROW_N0 = 4'd3,
      ROW_N1 = 4'd4,
      ROW_N2 = 4'd5,
      ROW_T  = 4'd6,
      ROW_N3 = 4'd7,
      ROW_CN = 4'd8,
      ROW_N5 = 4'd9,
      ROW_N6 = 4'd10,
      ROW_S  = 4'd11
   } row_e;

   localparam int unsigned NUM_ROWS      = 16;
   localparam int unsigned UOPS_PER_BIT  = 9;
   localparam int unsigned STEP_W        = $clog2(UOPS_PER_BIT);

   typedef struct packed {
      row_e src_a;
      row_e src_b;
      row_e dst;
   } uop_t;

   // Fixed per-bit micro-program: XNOR (0..3), carry (4..5), sum (6..8)
   function automatic uop_t uop_at(input logic [STEP_W-1:0] k);
      uop_t u;
      case (k)
         4'd0:    u = '{ROW_C,  ROW_NA, ROW_N0};
         4'd1:    u = '{ROW_N0, ROW_C,  ROW_N1};
         4'd2:    u = '{ROW_N0, ROW_NA, ROW_N2};
         4'd3:    u = '{ROW_N1, ROW_N2, ROW_T };
         4'd4:    u = '{ROW_T,  ROW_B,  ROW_N3};
         4'd5:    u = '{ROW_N3, ROW_N0, ROW_CN};
         4'd6:    u = '{ROW_T,  ROW_N3, ROW_N5};
         4'd7:    u = '{ROW_B,  ROW_N3, ROW_N6};
         default: u = '{ROW_N5, ROW_N6, ROW_S };
      endcase
      return u;
   endfunction

endpackage

// File: rtl/nsub_nor2.sv
module nsub_nor2 (
   input  logic a,
   input  logic b,
   output logic y
);
   assign y = ~(a | b);
endmodule

// File: rtl/nsub_nor_array.sv
module nsub_nor_array
   import nsub_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec,
   input  logic [STEP_W-1:0] step,
   input  logic              c_bit,
   input  logic              na_bit,
   input  logic              b_bit,
   output logic              nor_bit,
   output logic              cn_bit
);

   uop_t                op;
   logic [NUM_ROWS-1:0] rows_q;
   logic [NUM_ROWS-1:0] view;

   assign op = uop_at(step);

   always_comb begin
      view         = rows_q;
      view[ROW_C]  = c_bit;
      view[ROW_NA] = na_bit;
      view[ROW_B]  = b_bit;
   end

   nsub_nor2 u_gate (
      .a (view[op.src_a]),
      .b (view[op.src_b]),
      .y (nor_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    rows_q <= '0;
      else if (exec) rows_q[op.dst] <= nor_bit;
   end

   assign cn_bit = rows_q[ROW_CN];

   // R4
   xnor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && step == STEP_W'(3)) |-> (nor_bit == ~(c_bit ^ na_bit)));

   // R4
   carry_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && step == STEP_W'(6)) |->
      (cn_bit == ((c_bit & na_bit) | (b_bit & (c_bit ^ na_bit)))));

   // R4
   sum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && step == STEP_W'(8)) |-> (nor_bit == (c_bit ^ na_bit ^ b_bit)));

endmodule

// File: rtl/nsub_operand.sv
module nsub_operand #(
   parameter int unsigned W      = 16,
   parameter int unsigned ACCESS = 0,
   localparam int unsigned IDX_W = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] c_in,
   input  logic [W-1:0] na_in,
   input  logic         advance,
   input  logic         sum_bit,
   output logic         c_bit,
   output logic         na_bit,
   output logic         last_bit,
   output logic [W-1:0] acc_nxt
);

   logic [IDX_W-1:0] bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       bit_q <= '0;
      else if (load)    bit_q <= '0;
      else if (advance) bit_q <= bit_q + IDX_W'(1);
   end

   assign last_bit = (bit_q == IDX_W'(W - 1));

   if (ACCESS == 0) begin : g_shift
      logic [W-1:0] c_q, na_q, acc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= '0; na_q <= '0; acc_q <= '0;
         end else if (load) begin
            c_q <= c_in; na_q <= na_in; acc_q <= '0;
         end else if (advance) begin
            c_q   <= c_q  >> 1;
            na_q  <= na_q >> 1;
            acc_q <= acc_nxt;
         end
      end
      assign c_bit   = c_q[0];
      assign na_bit  = na_q[0];
      assign acc_nxt = {sum_bit, acc_q[W-1:1]};
   end else begin : g_index
      logic [W-1:0] c_q, na_q, acc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= '0; na_q <= '0; acc_q <= '0;
         end else if (load) begin
            c_q <= c_in; na_q <= na_in; acc_q <= '0;
         end else if (advance) begin
            acc_q <= acc_nxt;
         end
      end
      assign c_bit  = c_q[bit_q];
      assign na_bit = na_q[bit_q];
      always_comb begin
         acc_nxt        = acc_q;
         acc_nxt[bit_q] = sum_bit;
      end
   end

endmodule

// File: rtl/nor_serial_sub.sv
module nor_serial_sub
   import nsub_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned ACCESS = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] c_in,
   input  logic [W-1:0] na_in,
   output logic [W-1:0] diff_out,
   output logic         done_out
);

   if (W < 2) begin : g_bad_width
      $error("nor_serial_sub: W must be at least 2");
   end
   if (ACCESS > 1) begin : g_bad_access
      $error("nor_serial_sub: ACCESS must be 0 or 1");
   end

   localparam logic [STEP_W-1:0] LAST_UOP = STEP_W'(UOPS_PER_BIT - 1);

   logic              busy_q, done_q, carry_q;
   logic [STEP_W-1:0] step_q;
   logic [W-1:0]      diff_q, acc_nxt;
   logic              load, last_uop, advance, finish;
   logic              c_bit, na_bit, last_bit, nor_bit, cn_bit;

   assign load     = start && !busy_q;
   assign last_uop = (step_q == LAST_UOP);
   assign advance  = busy_q && last_uop;
   assign finish   = advance && last_bit;

   nsub_operand #(.W(W), .ACCESS(ACCESS)) u_opnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .c_in     (c_in),
      .na_in    (na_in),
      .advance  (advance),
      .sum_bit  (nor_bit),
      .c_bit    (c_bit),
      .na_bit   (na_bit),
      .last_bit (last_bit),
      .acc_nxt  (acc_nxt)
   );

   nsub_nor_array u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec    (busy_q),
      .step    (step_q),
      .c_bit   (c_bit),
      .na_bit  (na_bit),
      .b_bit   (carry_q),
      .nor_bit (nor_bit),
      .cn_bit  (cn_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         carry_q <= 1'b0;
         step_q  <= '0;
         diff_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q  <= 1'b1;
            carry_q <= 1'b0;
            step_q  <= '0;
         end else if (busy_q) begin
            if (last_uop) begin
               step_q  <= '0;
               carry_q <= cn_bit;
               if (last_bit) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  diff_q <= acc_nxt;
               end
            end else begin
               step_q <= step_q + STEP_W'(1);
            end
         end
      end
   end

   assign diff_out = diff_q;
   assign done_out = done_q;

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5
   carry_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (!carry_q && step_q == '0));

   // R8
   step_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_uop) |=> (busy_q && step_q == STEP_W'($past(step_q) + STEP_W'(1))));

   // R10
   diff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !finish) |=> $stable(diff_q));

   // R3
   idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (step_q == '0));

endmodule

// File: tb/sim_nor_serial_sub.sv
`timescale 1ns/1ps
module sim_nor_serial_sub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st0 = 1'b0, st1 = 1'b0;
   logic [15:0] c0 = '0, na0 = '0, d0;
   logic [3:0]  c1 = '0, na1 = '0, d1;
   logic        dn0, dn1;
   int          errors = 0;
   int          checks = 0;

   always #2.5 clk = ~clk;

   nor_serial_sub #(.W(16), .ACCESS(0)) u0 (
      .clk(clk), .rst_n(rst_n), .start(st0), .c_in(c0), .na_in(na0),
      .diff_out(d0), .done_out(dn0));

   nor_serial_sub #(.W(4), .ACCESS(1)) u1 (
      .clk(clk), .rst_n(rst_n), .start(st1), .c_in(c1), .na_in(na1),
      .diff_out(d1), .done_out(dn1));

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mask_of(input int sel);
      return (sel == 0) ? 16'hFFFF : 16'h000F;
   endfunction

   function automatic logic [15:0] ref_diff(input int sel, input logic [15:0] c, input logic [15:0] a);
      return (c - a) & mask_of(sel);
   endfunction

   function automatic logic [15:0] get_diff(input int sel);
      return (sel == 0) ? d0 : {12'h000, d1};
   endfunction

   function automatic logic get_done(input int sel);
      return (sel == 0) ? dn0 : dn1;
   endfunction

   task automatic drive(input int sel, input logic s, input logic [15:0] c, input logic [15:0] na);
      if (sel == 0) begin st0 = s; c0 = c; na0 = na; end
      else begin st1 = s; c1 = c[3:0]; na1 = na[3:0]; end
   endtask

   // disturb: inject a busy start with new operands and change inputs mid-run
   task automatic run_op(input int sel, input logic [15:0] c, input logic [15:0] a,
                         input string req, input bit disturb);
      int w;
      logic [15:0] m, na, exp, prev;
      w    = (sel == 0) ? 16 : 4;
      m    = mask_of(sel);
      na   = (~a + 16'd1) & m;
      exp  = ref_diff(sel, c, a);
      prev = get_diff(sel);
      @(negedge clk);
      drive(sel, 1'b1, c & m, na);
      @(negedge clk);
      drive(sel, 1'b0, c & m, na);
      for (int k = 1; k < 9 * w; k++) begin
         @(negedge clk);
         if (disturb && k == 10) drive(sel, 1'b1, 16'h1357 & m, 16'h2468 & m);
         if (disturb && k == 11) drive(sel, 1'b0, 16'hBEEF & m, 16'h0F0F & m);
         if (disturb && k == 20) chk(get_diff(sel) == prev, "R10 diff held during run", get_diff(sel), prev);
      end
      chk(get_done(sel) == 1'b0, {req, " R3 done not early"}, {15'd0, get_done(sel)}, 16'd0);
      @(negedge clk);
      chk(get_done(sel) == 1'b1, {req, " R3 done at 9*W"}, {15'd0, get_done(sel)}, 16'd1);
      chk(get_diff(sel) == exp, {req, " R2 difference"}, get_diff(sel), exp);
      @(negedge clk);
      chk(get_done(sel) == 1'b0, {req, " R3 single-cycle done"}, {15'd0, get_done(sel)}, 16'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20231));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(d0 == 16'h0 && dn0 == 1'b0, "R1 reset state u0", d0, 16'h0);
      chk(d1 == 4'h0 && dn1 == 1'b0, "R1 reset state u1", {12'h0, d1}, 16'h0);

      // R5 zero carry-in
      run_op(0, 16'h0000, 16'h0000, "R5 zero-zero", 1'b0);
      run_op(0, 16'h1234, 16'h0000, "R5 subtract zero", 1'b0);
      // R6 full carry ripple, equal operands
      run_op(0, 16'h0001, 16'h0001, "R6 ripple", 1'b0);
      run_op(0, 16'hA5A5, 16'hA5A5, "R6 equal operands", 1'b0);
      // R7 carry-out dropped
      run_op(0, 16'hFFFF, 16'h0001, "R7 drop carry", 1'b0);
      run_op(0, 16'hFFFF, 16'hFFFF, "R7 all ones equal", 1'b0);
      run_op(0, 16'h0000, 16'h0001, "R2 borrow wrap", 1'b0);
      run_op(0, 16'h0000, 16'hFFFF, "R2 minus all ones", 1'b0);
      // R8 R9 start and operand changes mid-run ignored
      run_op(0, 16'h8001, 16'h7FFF, "R8 R9 disturbed run", 1'b1);
      // R4 random patterns exercise the micro-program
      for (int i = 0; i < 40; i++)
         run_op(0, 16'($urandom), 16'($urandom), "R4 random", 1'b0);
      // R11 exhaustive narrow instance with indexed access
      for (int ci = 0; ci < 16; ci++)
         for (int ai = 0; ai < 16; ai++)
            run_op(1, 16'(ci), 16'(ai), "R11 exhaustive", 1'b0);
      run_op(1, 16'h000F, 16'h0003, "R8 R11 disturbed narrow", 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule